// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This unit sits at the commit point of an in-order core. Three exception sources can be pending there: an instruction translation miss, an attempt to issue a vector operation while the vector unit is unavailable, and a debug condition. When one of them is accepted, the unit squashes the faulting instruction with a single-cycle flush and drives the fetch redirect address in the same cycle. On the following clock edge it commits all architectural side effects together. The effective address and the prior state word go into a save/restore pair, which is either the host pair or a separate guest pair. The state word is rewritten according to per-field rules that depend on the exception type, and the vector-unavailable flag is set in the syndrome register when that exception is taken.

The redirect address is the 20-bit vector base prefix with a fixed 12-bit offset placed below it. The state word, the two save pairs and the syndrome register are held in the unit. The core's move-to-register path loads them through a single write port, and when both happen in the same cycle an exception wins over that write. A synchronous active-low reset clears every held register.

Top module: `exc_entry_unit`

## Requirements
- R1: A translation miss request causes `flush`=1 in the same cycle, with `redirect_pc` = {`vec_base`, 12'h1E0} and `taken_kind`=1.
- R2: A translation miss is saved into the guest pair (GSRR0/GSRR1) when `ctl_itlb_guest`=1 and state bit GS (bit 28) is 1. Otherwise it goes to the host pair (SRR0/SRR1). The redirect address is the same in both cases.
- R3: A vector request is taken only when state bit SPV (bit 24) is 0. It then redirects to {`vec_base`, 12'h200} with `taken_kind`=2. With SPV=1 the request has no effect on any output or register.
- R4: A debug exception is taken only when `dbg_status` is nonzero, `dbg_int_mode`=1 and state bit DE (bit 9) is 1. It redirects to {`vec_base`, 12'h040}, uses the host pair and gives `taken_kind`=3.
- R5: On any taken exception, the selected SRR0/GSRR0 receives `fault_ea` and the selected SRR1/GSRR1 receives the state word as it was before the exception.
- R6: After a translation miss, state bit CM (bit 31) equals `ctl_icm`. Bits CE (17), ME (12) and DE (9) keep their old values, and every other bit is 0.
- R7: After a vector exception, CM equals `ctl_icm`. CE, ME, DE and state bit ICM (bit 25) are kept and every other bit is 0. Syndrome bit 7 is set to 1 and the other syndrome bits are kept.
- R8: After a debug exception, CM equals `ctl_icm` and CE and ME are kept. Every other bit is 0, including DE.
- R9: When several exceptions are pending together, the translation miss wins over the vector exception, which wins over debug. Only one exception is taken per cycle.
- R10: Registers outside an exception's update list keep their values: the unselected save pair, and the syndrome register on translation-miss and debug exceptions. With no exception taken, `flush`=0, `taken_kind`=0 and `redirect_pc`=0.
- R11: When `rst_n` is low at a clock edge, the state word, all four save registers and the syndrome register become 0.
- R12: With `sr_wr_en`=1 and no exception taken, `sr_wr_data` is written to the register chosen by `sr_wr_sel`: 0 state, 1 SRR0, 2 SRR1, 3 GSRR0, 4 GSRR1, 5 syndrome. An exception in the same cycle cancels the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| itlb_miss_req | input | 1 | Fetch translation miss pending on the committing instruction |
| vec_op_req | input | 1 | Committing instruction is a vector operation recognized by the vector unit |
| dbg_status | input | 32 | Debug status register contents |
| dbg_int_mode | input | 1 | Internal debug mode enable |
| fault_ea | input | 32 | Effective address of the committing instruction |
| ctl_icm | input | 1 | Computation mode to load into CM on exception entry |
| ctl_itlb_guest | input | 1 | Direct translation misses to the guest pair |
| vec_base | input | 20 | Vector base prefix |
| sr_wr_en | input | 1 | Register write strobe |
| sr_wr_sel | input | 3 | Register write select |
| sr_wr_data | input | 32 | Register write data |
| flush | output | 1 | Squash pulse in the cycle an exception is taken |
| redirect_pc | output | 32 | Fetch restart address |
| taken_kind | output | 2 | 0 none, 1 translation miss, 2 vector, 3 debug |
| state_q | output | 32 | State word |
| srr0_q | output | 32 | Host save register 0 |
| srr1_q | output | 32 | Host save register 1 |
| gsrr0_q | output | 32 | Guest save register 0 |
| gsrr1_q | output | 32 | Guest save register 1 |
| synd_q | output | 32 | Syndrome register |

## Verification
The hardest cases to reach from the ports depend on the held state word. Whether a vector request is ignored, whether debug is allowed, and whether a miss goes to the guest pair all hinge on bits that only the register write port can set. Each vector therefore first loads a chosen state word, syndrome and four distinct save values through that port, then applies one combination of requests and controls. A 12-bit sweep covers every combination of the three requests, the gating state bits, the kept state bits and the control inputs. Separate cases cover an exception colliding with a write and a reset in mid-run.

// File: rtl/exc_pkg.sv
// Shared types and field positions for the exception entry unit.
// Assumes a state word of at least 32 bits; positions below are fixed.
package exc_pkg;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_ITLB = 2'd1,
        EXC_VEC  = 2'd2,
        EXC_DBG  = 2'd3
    } exc_kind_e;

    // State word field positions
    localparam int P_CM  = 31;
    localparam int P_GS  = 28;
    localparam int P_ICM = 25;
    localparam int P_SPV = 24;
    localparam int P_CE  = 17;
    localparam int P_ME  = 12;
    localparam int P_DE  = 9;

    // Syndrome field position
    localparam int P_SYN_SPV = 7;

    // Register write select codes
    localparam logic [2:0] SEL_STATE = 3'd0;
    localparam logic [2:0] SEL_SRR0  = 3'd1;
    localparam logic [2:0] SEL_SRR1  = 3'd2;
    localparam logic [2:0] SEL_GSRR0 = 3'd3;
    localparam logic [2:0] SEL_GSRR1 = 3'd4;
    localparam logic [2:0] SEL_SYND  = 3'd5;

    // Fixed vector offsets per exception kind
    function automatic logic [11:0] vec_offset(exc_kind_e k);
        case (k)
            EXC_ITLB: vec_offset = 12'h1E0;
            EXC_VEC:  vec_offset = 12'h200;
            EXC_DBG:  vec_offset = 12'h040;
            default:  vec_offset = 12'h000;
        endcase
    endfunction

    // Whether state bit idx keeps its old value on entry for kind k
    function automatic logic keep_bit(exc_kind_e k, int idx);
        logic base_keep;
        base_keep = (idx == P_CE) || (idx == P_ME);
        case (k)
            EXC_ITLB: keep_bit = base_keep || (idx == P_DE);
            EXC_VEC:  keep_bit = base_keep || (idx == P_DE) || (idx == P_ICM);
            EXC_DBG:  keep_bit = base_keep;
            default:  keep_bit = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
// Qualifies the three exception sources and picks one by fixed priority.
// Assumes requests belong to the instruction currently at commit.
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      itlb_req,
    input  logic      vec_req,
    input  logic      spv,
    input  logic      dbg_any,
    input  logic      dbg_mode,
    input  logic      dbg_en,
    output exc_kind_e kind
);

    logic vec_ok;
    logic dbg_ok;

    // Gate each source by its enabling state
    always_comb begin
        vec_ok = vec_req && !spv;
        dbg_ok = dbg_any && dbg_mode && dbg_en;
    end

    // Priority: translation miss, then vector, then debug
    always_comb begin
        if (itlb_req)    kind = EXC_ITLB;
        else if (vec_ok) kind = EXC_VEC;
        else if (dbg_ok) kind = EXC_DBG;
        else             kind = EXC_NONE;
    end

endmodule

// File: rtl/exc_state_rewrite.sv
// Builds the state word loaded on exception entry from per-field rules:
// CM is copied from the control input, the kind's keep set is preserved,
// and everything else is cleared. Assumes XLEN covers all field positions.
module exc_state_rewrite
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  exc_kind_e        kind,
    input  logic [XLEN-1:0]  cur,
    input  logic             icm,
    output logic [XLEN-1:0]  nxt
);

    // One rule per bit, chosen at elaboration from the field position
    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        if (b == P_CM) begin : g_cm
            assign nxt[b] = icm;
        end else begin : g_rule
            assign nxt[b] = keep_bit(kind, b) ? cur[b] : 1'b0;
        end
    end

endmodule

// File: rtl/exc_vector_gen.sv
// Forms the fetch restart address by placing the fixed offset for the
// chosen kind below the vector base prefix. Drives zero when nothing is taken.
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 12
) (
    input  exc_kind_e              kind,
    input  logic [XLEN-OFF_W-1:0]  base,
    output logic [XLEN-1:0]        pc
);

    logic [OFF_W-1:0] off;

    // Concatenate base with the kind's offset
    always_comb begin
        off = OFF_W'(vec_offset(kind));
        pc  = (kind == EXC_NONE) ? '0 : {base, off};
    end

endmodule

// File: rtl/exc_entry_unit.sv
// Exception entry at commit: arbitrates sources, flushes and redirects in
// the taken cycle, and commits save registers, state word and syndrome on
// the next edge. Assumes one committing instruction per cycle.
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int OFF_W  = 12,
    parameter int DSTAT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   itlb_miss_req,
    input  logic                   vec_op_req,
    input  logic [DSTAT_W-1:0]     dbg_status,
    input  logic                   dbg_int_mode,
    input  logic [XLEN-1:0]        fault_ea,
    input  logic                   ctl_icm,
    input  logic                   ctl_itlb_guest,
    input  logic [XLEN-OFF_W-1:0]  vec_base,
    input  logic                   sr_wr_en,
    input  logic [2:0]             sr_wr_sel,
    input  logic [XLEN-1:0]        sr_wr_data,
    output logic                   flush,
    output logic [XLEN-1:0]        redirect_pc,
    output logic [1:0]             taken_kind,
    output logic [XLEN-1:0]        state_q,
    output logic [XLEN-1:0]        srr0_q,
    output logic [XLEN-1:0]        srr1_q,
    output logic [XLEN-1:0]        gsrr0_q,
    output logic [XLEN-1:0]        gsrr1_q,
    output logic [XLEN-1:0]        synd_q
);

    exc_kind_e       kind;
    logic [XLEN-1:0] state_nxt;
    logic            dbg_any;
    logic            taken;
    logic            to_guest;

    // Any debug status bit pending
    assign dbg_any = |dbg_status;

    exc_arbiter arb_i (
        .itlb_req (itlb_miss_req),
        .vec_req  (vec_op_req),
        .spv      (state_q[P_SPV]),
        .dbg_any  (dbg_any),
        .dbg_mode (dbg_int_mode),
        .dbg_en   (state_q[P_DE]),
        .kind     (kind)
    );

    exc_state_rewrite #(.XLEN(XLEN)) rw_i (
        .kind (kind),
        .cur  (state_q),
        .icm  (ctl_icm),
        .nxt  (state_nxt)
    );

    exc_vector_gen #(.XLEN(XLEN), .OFF_W(OFF_W)) vg_i (
        .kind (kind),
        .base (vec_base),
        .pc   (redirect_pc)
    );

    // Taken strobe and save pair choice
    always_comb begin
        taken      = (kind != EXC_NONE);
        to_guest   = (kind == EXC_ITLB) && ctl_itlb_guest && state_q[P_GS];
        flush      = taken;
        taken_kind = kind;
    end

    // Commit all architectural updates together; exceptions beat writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            srr0_q  <= '0;
            srr1_q  <= '0;
            gsrr0_q <= '0;
            gsrr1_q <= '0;
            synd_q  <= '0;
        end else if (taken) begin
            state_q <= state_nxt;
            if (to_guest) begin
                gsrr0_q <= fault_ea;
                gsrr1_q <= state_q;
            end else begin
                srr0_q <= fault_ea;
                srr1_q <= state_q;
            end
            if (kind == EXC_VEC) begin
                synd_q[P_SYN_SPV] <= 1'b1;
            end
        end else if (sr_wr_en) begin
            case (sr_wr_sel)
                SEL_STATE: state_q <= sr_wr_data;
                SEL_SRR0:  srr0_q  <= sr_wr_data;
                SEL_SRR1:  srr1_q  <= sr_wr_data;
                SEL_GSRR0: gsrr0_q <= sr_wr_data;
                SEL_GSRR1: gsrr1_q <= sr_wr_data;
                SEL_SYND:  synd_q  <= sr_wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
// Property checker for exc_entry_unit, attached by bind below.
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int OFF_W   = 12,
    parameter int DSTAT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  itlb_miss_req,
    input logic                  vec_op_req,
    input logic [DSTAT_W-1:0]    dbg_status,
    input logic                  dbg_int_mode,
    input logic [XLEN-1:0]       fault_ea,
    input logic                  ctl_icm,
    input logic                  ctl_itlb_guest,
    input logic [XLEN-OFF_W-1:0] vec_base,
    input logic                  flush,
    input logic [XLEN-1:0]       redirect_pc,
    input logic [1:0]            taken_kind,
    input logic [XLEN-1:0]       state_q,
    input logic [XLEN-1:0]       srr0_q,
    input logic [XLEN-1:0]       srr1_q,
    input logic [XLEN-1:0]       gsrr0_q,
    input logic [XLEN-1:0]       gsrr1_q,
    input logic [XLEN-1:0]       synd_q
);

    logic [XLEN-1:0] allow_m;
    logic            dbg_cond;

    // Bits that may be nonzero right after any entry
    always_comb begin
        allow_m        = '0;
        allow_m[P_CM]  = 1'b1;
        allow_m[P_ICM] = 1'b1;
        allow_m[P_CE]  = 1'b1;
        allow_m[P_ME]  = 1'b1;
        allow_m[P_DE]  = 1'b1;
        dbg_cond = (|dbg_status) && dbg_int_mode && state_q[P_DE];
    end

    // R1
    itlb_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        itlb_miss_req |-> flush && redirect_pc == {vec_base, OFF_W'(12'h1E0)});

    // R2
    guest_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (itlb_miss_req && ctl_itlb_guest && state_q[P_GS])
        |=> gsrr0_q == $past(fault_ea) && srr0_q == $past(srr0_q));

    // R3
    vec_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!itlb_miss_req && vec_op_req && state_q[P_SPV] && !dbg_cond) |-> !flush);

    // R5
    saved_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (srr1_q == $past(state_q) || gsrr1_q == $past(state_q)));

    // R6
    cm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> state_q[P_CM] == $past(ctl_icm) && (state_q & ~allow_m) == '0);

    // R7
    synd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!itlb_miss_req && vec_op_req && !state_q[P_SPV]) |=> synd_q[P_SYN_SPV]);

    // R8
    dbg_de_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_kind == 2'd3) |=> !state_q[P_DE]);

    // R9
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (itlb_miss_req && vec_op_req) |-> taken_kind == 2'd1);

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> redirect_pc == '0 && taken_kind == 2'd0);

endmodule

bind exc_entry_unit exc_entry_chk #(.XLEN(XLEN), .OFF_W(OFF_W), .DSTAT_W(DSTAT_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .itlb_miss_req  (itlb_miss_req),
    .vec_op_req     (vec_op_req),
    .dbg_status     (dbg_status),
    .dbg_int_mode   (dbg_int_mode),
    .fault_ea       (fault_ea),
    .ctl_icm        (ctl_icm),
    .ctl_itlb_guest (ctl_itlb_guest),
    .vec_base       (vec_base),
    .flush          (flush),
    .redirect_pc    (redirect_pc),
    .taken_kind     (taken_kind),
    .state_q        (state_q),
    .srr0_q         (srr0_q),
    .srr1_q         (srr1_q),
    .gsrr0_q        (gsrr0_q),
    .gsrr1_q        (gsrr1_q),
    .synd_q         (synd_q)
);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        itlb_miss_req, vec_op_req, dbg_int_mode, ctl_icm, ctl_itlb_guest;
    logic [31:0] dbg_status, fault_ea, sr_wr_data;
    logic [19:0] vec_base;
    logic        sr_wr_en;
    logic [2:0]  sr_wr_sel;
    logic        flush;
    logic [31:0] redirect_pc, state_q, srr0_q, srr1_q, gsrr0_q, gsrr1_q, synd_q;
    logic [1:0]  taken_kind;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .itlb_miss_req(itlb_miss_req), .vec_op_req(vec_op_req),
        .dbg_status(dbg_status), .dbg_int_mode(dbg_int_mode), .fault_ea(fault_ea),
        .ctl_icm(ctl_icm), .ctl_itlb_guest(ctl_itlb_guest), .vec_base(vec_base),
        .sr_wr_en(sr_wr_en), .sr_wr_sel(sr_wr_sel), .sr_wr_data(sr_wr_data),
        .flush(flush), .redirect_pc(redirect_pc), .taken_kind(taken_kind),
        .state_q(state_q), .srr0_q(srr0_q), .srr1_q(srr1_q), .gsrr0_q(gsrr0_q),
        .gsrr1_q(gsrr1_q), .synd_q(synd_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; write lands at the next posedge
    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        sr_wr_en = 1'b1; sr_wr_sel = sel; sr_wr_data = data;
        @(negedge clk);
        sr_wr_en = 1'b0;
    endtask

    task automatic idle_inputs();
        itlb_miss_req = 0; vec_op_req = 0; dbg_status = 0; dbg_int_mode = 0;
        ctl_icm = 0; ctl_itlb_guest = 0; fault_ea = 0; vec_base = 0;
        sr_wr_en = 0; sr_wr_sel = 0; sr_wr_data = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 state", state_q, 0);
        chk("R11 srr0", srr0_q, 0);
        chk("R11 gsrr1", gsrr1_q, 0);
        chk("R11 synd", synd_q, 0);
        rst_n = 1;
        @(negedge clk);
        // R10 idle outputs
        chk("R10 idle flush", {31'b0, flush}, 0);
        chk("R10 idle pc", redirect_pc, 0);

        for (int i = 0; i < 4096; i++) begin
            logic [31:0] mix, st, syn, a0, a1, g0, g1, ea, ns, es;
            logic [31:0] e_s0, e_s1, e_g0, e_g1, e_pc;
            logic [11:0] off;
            logic [1:0]  kind;
            logic        spv, de, gs, dc, guest;
            string       tag;
            mix = (i * 32'h9E3779B9) ^ 32'h5A5A1234;
            st  = mix;
            st[0+24] = i[6]; st[9] = i[7]; st[28] = i[5]; st[25] = i[8];
            st[17] = i[9];   st[12] = i[10];
            syn = {mix[15:0], mix[31:16]};
            a0 = mix ^ 32'h1111_0000; a1 = mix ^ 32'h2222_0000;
            g0 = mix ^ 32'h3333_0000; g1 = mix ^ 32'h4444_0000;
            ea = ~mix;
            wr(3'd0, st); wr(3'd5, syn);
            wr(3'd1, a0); wr(3'd2, a1); wr(3'd3, g0); wr(3'd4, g1);
            // R12 write port loads
            chk("R12 state write", state_q, st);
            chk("R12 synd write", synd_q, syn);

            itlb_miss_req = i[0]; vec_op_req = i[1];
            dbg_status = i[2] ? (32'h1 << (i % 32)) : 32'h0;
            dbg_int_mode = i[3]; ctl_itlb_guest = i[4]; ctl_icm = i[11];
            fault_ea = ea; vec_base = mix[31:12];

            spv = st[24]; de = st[9]; gs = st[28];
            dc = i[2] && i[3] && de;
            if (i[0])             begin kind = 2'd1; off = 12'h1E0; tag = "R1"; end
            else if (i[1] && !spv) begin kind = 2'd2; off = 12'h200; tag = "R3"; end
            else if (dc)          begin kind = 2'd3; off = 12'h040; tag = "R4"; end
            else                  begin kind = 2'd0; off = 12'h000; tag = "R10"; end
            e_pc = (kind == 0) ? 32'h0 : {mix[31:12], off};
            guest = (kind == 2'd1) && i[4] && gs;
            ns = 32'h0;
            ns[31] = i[11];
            ns[17] = st[17]; ns[12] = st[12];
            if (kind == 2'd1 || kind == 2'd2) ns[9] = st[9];
            if (kind == 2'd2) ns[25] = st[25];
            if (kind == 2'd0) ns = st;
            es = syn;
            if (kind == 2'd2) es[7] = 1'b1;
            e_s0 = a0; e_s1 = a1; e_g0 = g0; e_g1 = g1;
            if (kind != 0) begin
                if (guest) begin e_g0 = ea; e_g1 = st; end
                else       begin e_s0 = ea; e_s1 = st; end
            end

            #1;
            // R9 priority, R1/R3/R4 redirect
            chk({tag, " R9 kind"}, {30'b0, taken_kind}, {30'b0, kind});
            chk({tag, " flush"}, {31'b0, flush}, {31'b0, kind != 0});
            chk({tag, " pc"}, redirect_pc, e_pc);
            @(negedge clk);
            itlb_miss_req = 0; vec_op_req = 0; dbg_status = 0;
            // R6 R7 R8 state rewrite
            chk(kind == 1 ? "R6 state" : kind == 2 ? "R7 state" : kind == 3 ? "R8 state" : "R10 state",
                state_q, ns);
            // R2 R5 save pairs, R10 unselected pair
            chk("R2 R5 srr0", srr0_q, e_s0);
            chk("R2 R5 srr1", srr1_q, e_s1);
            chk("R2 R5 gsrr0", gsrr0_q, e_g0);
            chk("R2 R5 gsrr1", gsrr1_q, e_g1);
            // R7 syndrome, R10 unchanged otherwise
            chk("R7 R10 synd", synd_q, es);
        end

        // R12 exception cancels a same-cycle write
        wr(3'd0, 32'h0);
        sr_wr_en = 1; sr_wr_sel = 3'd1; sr_wr_data = 32'hDEAD_BEEF;
        itlb_miss_req = 1; fault_ea = 32'h0000_1234;
        @(negedge clk);
        sr_wr_en = 0; itlb_miss_req = 0;
        chk("R12 collision srr0", srr0_q, 32'h0000_1234);

        // R11 reset mid-run clears held registers
        rst_n = 0;
        @(negedge clk);
        chk("R11 srr0 after reset", srr0_q, 0);
        chk("R11 gsrr0 after reset", gsrr0_q, 0);
        chk("R11 state after reset", state_q, 0);
        rst_n = 1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule